// File: doc/BRIEF.md
# Shadow Stack Leaf Page Permission Checker

This block decides whether one memory access may use a leaf page-table entry, in a translation scheme where the write-without-read encoding marks a page as a shadow stack page. A request arrives with its access class, the leaf's execute, write, read and user bits, the effective privilege, the virtualization bit, a flag saying that translation is bare, the supervisor-user-access and make-executable-readable controls, and two shadow stack enables: one at machine level and one at hypervisor level. One cycle after the request is accepted, the block returns either "allowed" or a fault kind and a fault type.

Shadow stack instructions push, swap and pop-check. They may only touch shadow stack pages, and every fault they raise is classified as store/AMO, even for the pop-check, which only reads. A read-only page gives these instructions a page fault, so copy-on-write can be handled. Any other leaf type gives them an access fault. Ordinary stores and fetches that reach a shadow stack page get an access fault. Ordinary loads may read such a page.

The control is a two-state machine. In `ST_IDLE` the block is ready. The transition `accept` (valid while ready) captures the verdict and moves to `ST_RESP`. In `ST_RESP` the response is presented for one cycle, the block is not ready, and the transition `return` goes back to `ST_IDLE` unconditionally.

Top module: `sspte_leaf_checker`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `rsp_valid` is 0, and both fault fields are 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is then 1 for exactly the next cycle, during which `req_ready` is 0. A request held valid while not ready is not accepted.
- R3: Class codes are: 0 load, 1 store/AMO, 2 fetch, 3 shadow push, 4 shadow swap, 5 shadow pop-check; codes 6 and 7 act as ordinary loads. Fault kind is 0 none, 1 access, 2 page. Fault type is 0 load, 1 store/AMO, 2 fetch. The type is 0 when the kind is none. Every fault of classes 3 to 5 has type 1. Privilege is 0 user, 1 supervisor, 3 machine.
- R4: When translated, a leaf with xwr=010 is a shadow stack page only if the enable is set: `m_ss_en` when `virt`=0, `h_ss_en` when `virt`=1. Otherwise that leaf is reserved. xwr=110 and xwr=000 are always reserved. A reserved leaf gives a page fault of the access's own type.
- R5: With `xlat_bare`=1 and privilege below machine, shadow stack classes give an access fault of type store, and all other classes are allowed.
- R6: At machine privilege no leaf check applies. A shadow swap gives an access fault of type store, and every other class is allowed.
- R7: An ordinary store to a shadow stack page gives an access fault of type store.
- R8: A fetch from a shadow stack page gives an access fault of type fetch.
- R9: An ordinary load from a shadow stack page is allowed whatever the value of `mxr_en`.
- R10: A shadow stack class, including pop-check, on a read-only leaf (xwr=001) gives a page fault of type store.
- R11: A shadow stack class on a leaf with xwr of 011, 111, 101 or 100 gives an access fault of type store.
- R12: User privilege with `pte_u`=0 gives a page fault. Supervisor privilege with `pte_u`=1 gives a page fault for fetches, and for other classes when `sum_en`=0.
- R13: An ordinary load needs R, or X together with `mxr_en`. A store needs W. A fetch needs X. A missing permission gives a page fault of the access's own type.
- R14: Checks are prioritised: reserved encoding first, then shadow stack type-mismatch access faults, then user and permission page faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_class | input | 3 | Access class code |
| pte_x | input | 1 | Leaf execute bit |
| pte_w | input | 1 | Leaf write bit |
| pte_r | input | 1 | Leaf read bit |
| pte_u | input | 1 | Leaf user bit |
| priv | input | 2 | Effective privilege |
| virt | input | 1 | Virtualization active |
| xlat_bare | input | 1 | Translation is bare |
| sum_en | input | 1 | Supervisor may access user pages |
| mxr_en | input | 1 | Executable pages are readable |
| m_ss_en | input | 1 | Machine-level shadow stack enable |
| h_ss_en | input | 1 | Hypervisor-level shadow stack enable |
| rsp_valid | output | 1 | Verdict present |
| rsp_fault_kind | output | 2 | 0 none, 1 access, 2 page |
| rsp_fault_type | output | 2 | 0 load, 1 store/AMO, 2 fetch |

## Verification
Every verdict is due exactly one cycle after the edge that accepts its request, and `req_ready` is due low in that same cycle. The bench model registers its expectation on the accepting edge. It compares the ready, valid, kind and type outputs at every falling edge, so a verdict that comes early, late or twice is a mismatch in that cycle. Each request is held valid for two cycles, so that the response cycle also tests that a request is not accepted while the block is not ready.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int CLS_W  = 3;
    localparam int PRIV_W = 2;
    localparam int KIND_W = 2;
    localparam int TYPE_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_LOAD      = 3'd0,
        CLS_STORE     = 3'd1,
        CLS_FETCH     = 3'd2,
        CLS_SS_PUSH   = 3'd3,
        CLS_SS_SWAP   = 3'd4,
        CLS_SS_POPCHK = 3'd5,
        CLS_SPARE6    = 3'd6,
        CLS_SPARE7    = 3'd7
    } acc_cls_e;

    typedef enum logic [KIND_W-1:0] {
        FK_NONE   = 2'd0,
        FK_ACCESS = 2'd1,
        FK_PAGE   = 2'd2,
        FK_SPARE  = 2'd3
    } fault_kind_e;

    typedef enum logic [TYPE_W-1:0] {
        FT_LOAD  = 2'd0,
        FT_STORE = 2'd1,
        FT_FETCH = 2'd2,
        FT_SPARE = 2'd3
    } fault_type_e;

    localparam logic [PRIV_W-1:0] PRIV_USER = 2'd0;
    localparam logic [PRIV_W-1:0] PRIV_SUP  = 2'd1;
    localparam logic [PRIV_W-1:0] PRIV_MACH = 2'd3;

    typedef struct packed {
        fault_kind_e kind;
        fault_type_e ftype;
    } verdict_t;
endpackage

// File: rtl/ssp_cls_decode.sv
module ssp_cls_decode
    import ssp_pkg::*;
(
    input  acc_cls_e    cls_i,
    output logic        ss_o,
    output logic        swap_o,
    output logic        store_o,
    output logic        fetch_o,
    output fault_type_e own_type_o
);
    always_comb begin
        ss_o       = 1'b0;
        swap_o     = 1'b0;
        store_o    = 1'b0;
        fetch_o    = 1'b0;
        own_type_o = FT_LOAD;
        case (cls_i)
            CLS_STORE: begin
                store_o    = 1'b1;
                own_type_o = FT_STORE;
            end
            CLS_FETCH: begin
                fetch_o    = 1'b1;
                own_type_o = FT_FETCH;
            end
            CLS_SS_PUSH, CLS_SS_POPCHK: begin
                ss_o       = 1'b1;
                own_type_o = FT_STORE;
            end
            CLS_SS_SWAP: begin
                ss_o       = 1'b1;
                swap_o     = 1'b1;
                own_type_o = FT_STORE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ssp_leaf_eval.sv
module ssp_leaf_eval
    import ssp_pkg::*;
(
    input  logic              ss_i,
    input  logic              swap_i,
    input  logic              store_i,
    input  logic              fetch_i,
    input  fault_type_e       own_type_i,
    input  logic              pte_x_i,
    input  logic              pte_w_i,
    input  logic              pte_r_i,
    input  logic              pte_u_i,
    input  logic [PRIV_W-1:0] priv_i,
    input  logic              virt_i,
    input  logic              bare_i,
    input  logic              sum_i,
    input  logic              mxr_i,
    input  logic              m_ss_en_i,
    input  logic              h_ss_en_i,
    output verdict_t          verdict_o
);
    logic [2:0] xwr;
    logic       ss_enabled;
    logic       ss_page;
    logic       reserved;
    logic       is_mach;
    logic       read_only;
    logic       user_fail;
    logic       perm_fail;
    logic       load_ok;

    assign xwr        = {pte_x_i, pte_w_i, pte_r_i};
    assign ss_enabled = virt_i ? h_ss_en_i : m_ss_en_i;
    assign ss_page    = (xwr == 3'b010) && ss_enabled;
    // write without read is reserved unless it is an enabled shadow stack page
    assign reserved   = ((pte_w_i && !pte_r_i) && !ss_page) || (xwr == 3'b000);
    assign is_mach    = (priv_i == PRIV_MACH);
    assign read_only  = (xwr == 3'b001);
    assign load_ok    = pte_r_i || (mxr_i && pte_x_i) || ss_page;

    always_comb begin
        if (priv_i == PRIV_USER) begin
            user_fail = !pte_u_i;
        end else begin
            user_fail = pte_u_i && (fetch_i || !sum_i);
        end
    end

    always_comb begin
        if (ss_i) begin
            perm_fail = 1'b0;
        end else if (store_i) begin
            perm_fail = !pte_w_i;
        end else if (fetch_i) begin
            perm_fail = !pte_x_i;
        end else begin
            perm_fail = !load_ok;
        end
    end

    always_comb begin
        verdict_o = '{kind: FK_NONE, ftype: FT_LOAD};
        if (ss_i && bare_i && !is_mach) begin
            verdict_o = '{kind: FK_ACCESS, ftype: FT_STORE};
        end else if (swap_i && is_mach) begin
            verdict_o = '{kind: FK_ACCESS, ftype: FT_STORE};
        end else if (bare_i || is_mach) begin
            verdict_o = '{kind: FK_NONE, ftype: FT_LOAD};
        end else if (reserved) begin
            verdict_o = '{kind: FK_PAGE, ftype: own_type_i};
        end else if (ss_i && !ss_page) begin
            verdict_o = '{kind: (read_only ? FK_PAGE : FK_ACCESS), ftype: FT_STORE};
        end else if (ss_page && store_i) begin
            verdict_o = '{kind: FK_ACCESS, ftype: FT_STORE};
        end else if (ss_page && fetch_i) begin
            verdict_o = '{kind: FK_ACCESS, ftype: FT_FETCH};
        end else if (user_fail || perm_fail) begin
            verdict_o = '{kind: FK_PAGE, ftype: own_type_i};
        end
    end
endmodule

// File: rtl/sspte_leaf_checker.sv
module sspte_leaf_checker
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CLS_W-1:0]  req_class,
    input  logic              pte_x,
    input  logic              pte_w,
    input  logic              pte_r,
    input  logic              pte_u,
    input  logic [PRIV_W-1:0] priv,
    input  logic              virt,
    input  logic              xlat_bare,
    input  logic              sum_en,
    input  logic              mxr_en,
    input  logic              m_ss_en,
    input  logic              h_ss_en,
    output logic              rsp_valid,
    output logic [KIND_W-1:0] rsp_fault_kind,
    output logic [TYPE_W-1:0] rsp_fault_type
);
    typedef enum logic {ST_IDLE, ST_RESP} state_e;

    state_e      state_q;
    state_e      state_d;
    verdict_t    verdict_d;
    verdict_t    verdict_q;
    logic        ss_q;
    logic        dec_ss;
    logic        dec_swap;
    logic        dec_store;
    logic        dec_fetch;
    fault_type_e dec_type;
    logic        accept;

    ssp_cls_decode u_dec (
        .cls_i      (acc_cls_e'(req_class)),
        .ss_o       (dec_ss),
        .swap_o     (dec_swap),
        .store_o    (dec_store),
        .fetch_o    (dec_fetch),
        .own_type_o (dec_type)
    );

    ssp_leaf_eval u_eval (
        .ss_i       (dec_ss),
        .swap_i     (dec_swap),
        .store_i    (dec_store),
        .fetch_i    (dec_fetch),
        .own_type_i (dec_type),
        .pte_x_i    (pte_x),
        .pte_w_i    (pte_w),
        .pte_r_i    (pte_r),
        .pte_u_i    (pte_u),
        .priv_i     (priv),
        .virt_i     (virt),
        .bare_i     (xlat_bare),
        .sum_i      (sum_en),
        .mxr_i      (mxr_en),
        .m_ss_en_i  (m_ss_en),
        .h_ss_en_i  (h_ss_en),
        .verdict_o  (verdict_d)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            verdict_q <= '{kind: FK_NONE, ftype: FT_LOAD};
            ss_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                verdict_q <= verdict_d;
                ss_q      <= dec_ss;
            end
        end
    end

    always_comb begin
        req_ready      = (state_q == ST_IDLE);
        rsp_valid      = (state_q == ST_RESP);
        rsp_fault_kind = rsp_valid ? verdict_q.kind  : FK_NONE;
        rsp_fault_type = rsp_valid ? verdict_q.ftype : FT_LOAD;
    end

    // R2
    accept_to_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R2
    single_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R3
    no_fault_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault_kind == 2'd0) |-> (rsp_fault_type == 2'd0));

    // R3
    kind_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault_kind != 2'd3);

    // R3
    ss_store_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && ss_q && rsp_fault_kind != 2'd0) |-> (rsp_fault_type == 2'd1));
endmodule

// File: tb/test_sspte_leaf_checker.sv
module test_sspte_leaf_checker;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_class = '0;
    logic       pte_x = 1'b0, pte_w = 1'b0, pte_r = 1'b0, pte_u = 1'b0;
    logic [1:0] priv = '0;
    logic       virt = 1'b0, xlat_bare = 1'b0, sum_en = 1'b0, mxr_en = 1'b0;
    logic       m_ss_en = 1'b0, h_ss_en = 1'b0;
    logic       rsp_valid;
    logic [1:0] rsp_fault_kind;
    logic [1:0] rsp_fault_type;

    int    checks = 0;
    int    failures = 0;
    bit    finished = 1'b0;
    bit    monitor_on = 1'b0;
    string cur_tag = "";
    bit    exp_valid = 1'b0;
    int    exp_kind = 0;
    int    exp_type = 0;
    string exp_tag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    sspte_leaf_checker i_sspte_leaf_checker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_class(req_class), .pte_x(pte_x), .pte_w(pte_w), .pte_r(pte_r),
        .pte_u(pte_u), .priv(priv), .virt(virt), .xlat_bare(xlat_bare),
        .sum_en(sum_en), .mxr_en(mxr_en), .m_ss_en(m_ss_en), .h_ss_en(h_ss_en),
        .rsp_valid(rsp_valid), .rsp_fault_kind(rsp_fault_kind),
        .rsp_fault_type(rsp_fault_type)
    );

    // Behavioural reference: returns expected kind, type and the rule that decided it.
    function automatic void model(input int cls, input int x, input int w, input int r,
                                  input int u, input int pv, input int v, input int bare,
                                  input int sm, input int mx, input int men, input int hen,
                                  output int k, output int t, output string tag);
        bit shadow = (cls == 3) || (cls == 4) || (cls == 5);
        int own;
        bit sspg;
        bit user_bad;
        if (shadow || cls == 1) own = 1;
        else if (cls == 2) own = 2;
        else own = 0;
        k = 0; t = 0; tag = "R13";
        if (pv == 3) begin
            tag = "R6";
            if (cls == 4) begin k = 1; t = 1; end
            return;
        end
        if (bare != 0) begin
            tag = "R5";
            if (shadow) begin k = 1; t = 1; end
            return;
        end
        sspg = (x == 0) && (w == 1) && (r == 0) && ((v != 0) ? (hen != 0) : (men != 0));
        if ((w == 1 && r == 0 && !sspg) || (x == 0 && w == 0 && r == 0)) begin
            k = 2; t = own; tag = "R4"; return;
        end
        if (shadow && !sspg) begin
            t = 1;
            if (x == 0 && w == 0 && r == 1) begin k = 2; tag = "R10"; end
            else begin k = 1; tag = "R11"; end
            return;
        end
        if (sspg && cls == 1) begin k = 1; t = 1; tag = "R7"; return; end
        if (sspg && cls == 2) begin k = 1; t = 2; tag = "R8"; return; end
        if (pv == 0) user_bad = (u == 0);
        else user_bad = (u == 1) && (cls == 2 || sm == 0);
        if (user_bad) begin k = 2; t = own; tag = "R12"; return; end
        if (shadow) begin tag = "R4"; return; end
        if (cls == 1) begin
            if (w == 0) begin k = 2; t = 1; end
        end else if (cls == 2) begin
            if (x == 0) begin k = 2; t = 2; end
        end else begin
            if (sspg) tag = "R9";
            else if (!(r == 1 || (mx == 1 && x == 1))) begin k = 2; t = 0; end
        end
    endfunction

    // Expected outputs, updated on the same edge the design registers.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_kind  <= 0;
            exp_type  <= 0;
        end else if (req_valid && !exp_valid) begin
            int k, t;
            string tg;
            model(int'(req_class), int'(pte_x), int'(pte_w), int'(pte_r), int'(pte_u),
                  int'(priv), int'(virt), int'(xlat_bare), int'(sum_en), int'(mxr_en),
                  int'(m_ss_en), int'(h_ss_en), k, t, tg);
            exp_valid <= 1'b1;
            exp_kind  <= k;
            exp_type  <= t;
            exp_tag   <= (cur_tag != "") ? cur_tag : tg;
        end else begin
            exp_valid <= 1'b0;
            exp_kind  <= 0;
            exp_type  <= 0;
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Compare every cycle, away from the active edge. R2 covers timing of valid/ready.
    always @(negedge clk) begin
        if (monitor_on && rst_n && !finished) begin
            check("R2", "req_ready", int'(req_ready), exp_valid ? 0 : 1);
            check("R2", "rsp_valid", int'(rsp_valid), int'(exp_valid));
            check(exp_valid ? exp_tag : "R3", "fault_kind", int'(rsp_fault_kind), exp_kind);
            check(exp_valid ? exp_tag : "R3", "fault_type", int'(rsp_fault_type), exp_type);
        end
    end

    // Request held valid two cycles: accepted on the first edge, refused on the second.
    task automatic send(input int cls, input int x, input int w, input int r, input int u,
                        input int pv, input int v, input int bare, input int sm, input int mx,
                        input int men, input int hen, input string tag);
        @(negedge clk);
        cur_tag   = tag;
        req_class = 3'(cls);
        pte_x = 1'(x); pte_w = 1'(w); pte_r = 1'(r); pte_u = 1'(u);
        priv = 2'(pv); virt = 1'(v); xlat_bare = 1'(bare);
        sum_en = 1'(sm); mxr_en = 1'(mx); m_ss_en = 1'(men); h_ss_en = 1'(hen);
        req_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: state held in reset
        check("R1", "reset req_ready", int'(req_ready), 1);
        check("R1", "reset rsp_valid", int'(rsp_valid), 0);
        check("R1", "reset kind", int'(rsp_fault_kind), 0);
        check("R1", "reset type", int'(rsp_fault_type), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "post-reset rsp_valid", int'(rsp_valid), 0);
        check("R1", "post-reset req_ready", int'(req_ready), 1);
        monitor_on = 1'b1;

        // Directed cases:   cls x w r u pv v bare sum mxr men hen
        send(3, 0,1,0, 1, 0, 0,0, 0,0, 1,0, "R5");   // ss page ok, then next bare
        send(4, 0,1,0, 1, 1, 0,1, 0,0, 1,1, "R5");   // R5 bare swap in S
        send(0, 0,0,0, 0, 0, 0,1, 0,0, 0,0, "R5");   // R5 bare load allowed
        send(4, 0,1,0, 1, 3, 0,0, 0,0, 1,1, "R6");   // R6 swap in M
        send(3, 0,0,0, 0, 3, 0,0, 0,0, 0,0, "R6");   // R6 push in M allowed
        send(0, 0,1,0, 1, 0, 1,0, 0,0, 1,0, "R4");   // R4 V=1 uses hyp enable (off)
        send(0, 0,1,0, 1, 0, 1,0, 0,0, 0,1, "R4");   // R4 V=1 hyp enable on: load ok
        send(2, 1,1,0, 1, 0, 0,0, 0,0, 1,1, "R4");   // R4 xwr=110 reserved fetch
        send(1, 0,1,0, 1, 0, 0,0, 0,0, 1,0, "R7");   // R7 store to ss page
        send(2, 0,1,0, 1, 0, 0,0, 0,0, 1,0, "R8");   // R8 fetch from ss page
        send(0, 0,1,0, 1, 0, 0,0, 0,1, 1,0, "R9");   // R9 load ss page, mxr=1
        send(0, 0,1,0, 1, 0, 0,0, 0,0, 1,0, "R9");   // R9 load ss page, mxr=0
        send(5, 0,0,1, 1, 0, 0,0, 0,0, 1,0, "R10");  // R10 popchk on read-only
        send(3, 1,1,1, 1, 0, 0,0, 0,0, 1,0, "R11");  // R11 push on rwx
        send(5, 1,0,0, 1, 0, 0,0, 0,0, 1,0, "R11");  // R11 popchk on x-only
        send(3, 0,1,0, 1, 1, 0,0, 0,0, 1,0, "R12");  // R12 S, user ss page, sum=0
        send(3, 0,1,0, 1, 1, 0,0, 1,0, 1,0, "R12");  // R12 S, user ss page, sum=1 ok
        send(2, 1,0,1, 1, 1, 0,0, 1,0, 0,0, "R12");  // R12 S fetch user page
        send(0, 1,0,0, 1, 0, 0,0, 0,1, 0,0, "R13");  // R13 load x-only with mxr
        send(1, 0,0,1, 1, 0, 0,0, 0,0, 0,0, "R13");  // R13 store read-only
        send(2, 0,1,0, 0, 0, 0,0, 0,0, 1,0, "R14");  // R14 fetch ss page, U bad -> access
        send(3, 0,1,0, 0, 0, 0,0, 0,0, 0,0, "R14");  // R14 disabled encoding -> page store
        send(7, 0,0,1, 1, 0, 0,0, 0,0, 0,0, "R3");   // R3 class 7 acts as load
        @(negedge clk);
        req_valid = 1'b0;
        cur_tag = "";
        repeat (3) @(negedge clk);

        // Sweep: each outcome is tagged by the rule the model applied.
        for (int cls = 0; cls < 6; cls++)
            for (int xwr = 0; xwr < 8; xwr++)
                for (int pi = 0; pi < 3; pi++)
                    for (int f = 0; f < 128; f++) begin
                        int pv = (pi == 2) ? 3 : pi;
                        send(cls, (xwr >> 2) & 1, (xwr >> 1) & 1, xwr & 1, f & 1, pv,
                             (f >> 1) & 1, (f >> 2) & 1, (f >> 3) & 1, (f >> 4) & 1,
                             (f >> 5) & 1, (f >> 6) & 1, "");
                    end
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule